// File: doc/BRIEF.md
# Microcoded Loop Counter with Zero Flag

This block holds an 8-bit iteration count for a microprogrammed processor. Each clock, a 2-bit operation field from the current microinstruction selects one action: keep the count, count down by one, take the low byte of the data bus, or take the micro-address field zero-extended to 8 bits. A registered loop flag tells the microsequencer that the count is zero, so microcode can branch out of a loop.

The flag is evaluated again only on cycles that change the count, and it always matches the value written on that same edge. On idle cycles it keeps its last value. Counting down from zero wraps to 0xFF and clears the flag.

Top module: `loop_counter`

## Requirements
- R1: While rst_ni is low, count_o is 0 and zero_flag_o is 0. Reset overrides any operation code.
- R2: Operation code 2'b00 leaves count_o and zero_flag_o unchanged.
- R3: Operation code 2'b01 decrements count_o by one at the clock edge, modulo 256, so 0 becomes 0xFF.
- R4: Operation code 2'b10 loads bus_i[7:0] into count_o. All higher bus bits are ignored.
- R5: Operation code 2'b11 loads the 7 low bits of uaddr_i into count_o, with count_o[7] set to 0.
- R6: After an edge with code 01, 10 or 11, zero_flag_o is 1 exactly when the new count_o is 0. It updates on the same edge as count_o.
- R7: Repeated loads of zero keep zero_flag_o at 1. The next non-zero result clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 2 | Operation code (microinstruction bits 13:12) |
| bus_i | input | BUS_W | Data bus word |
| uaddr_i | input | UADDR_W | Micro-address field |
| count_o | output | 8 | Counter value |
| zero_flag_o | output | 1 | Loop flag, 1 when the last active operation left zero |

## Verification
The hardest state to reach from the ports is an idle cycle that follows a result of zero. Only that cycle shows whether the flag is held or recomputed. Another hard case is a decrement from zero, which must wrap to 0xFF and clear the flag. Random operation codes are weighted towards loads of zero and towards chains of decrements starting from small counts. Directed sequences load zero, idle, count down through zero, and load bus words whose upper bits are set.

// File: rtl/loop_counter_pkg.sv
package loop_counter_pkg;
  localparam int unsigned CNT_W = 8;
  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_DEC  = 2'b01,
    OP_BUS  = 2'b10,
    OP_UADR = 2'b11
  } lc_op_e;
endpackage

// File: rtl/lc_next.sv
module lc_next
  import loop_counter_pkg::*;
#(
  parameter int unsigned BUS_W   = 16,
  parameter int unsigned UADDR_W = 7
) (
  input  logic [1:0]         op_i,
  input  logic [CNT_W-1:0]   cur_i,
  input  logic [BUS_W-1:0]   bus_i,
  input  logic [UADDR_W-1:0] uaddr_i,
  output logic [CNT_W-1:0]   nxt_o,
  output logic               act_o
);
  localparam int unsigned UA_USE = (UADDR_W < 7) ? UADDR_W : 7;

  logic [CNT_W-1:0] bus_ld, ua_ld;

  generate
    if (BUS_W >= CNT_W) begin : g_bus_trunc
      assign bus_ld = bus_i[CNT_W-1:0];
    end else begin : g_bus_ext
      assign bus_ld = {{(CNT_W-BUS_W){1'b0}}, bus_i};
    end
  endgenerate

  assign ua_ld = {{(CNT_W-UA_USE){1'b0}}, uaddr_i[UA_USE-1:0]};

  always_comb begin
    act_o = 1'b1;
    unique case (lc_op_e'(op_i))
      OP_DEC:  nxt_o = cur_i - 1'b1;
      OP_BUS:  nxt_o = bus_ld;
      OP_UADR: nxt_o = ua_ld;
      default: begin
        nxt_o = cur_i;
        act_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/loop_counter.sv
module loop_counter
  import loop_counter_pkg::*;
#(
  parameter int unsigned BUS_W   = 16,
  parameter int unsigned UADDR_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         op_i,
  input  logic [BUS_W-1:0]   bus_i,
  input  logic [UADDR_W-1:0] uaddr_i,
  output logic [CNT_W-1:0]   count_o,
  output logic               zero_flag_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, act;

  lc_next #(.BUS_W(BUS_W), .UADDR_W(UADDR_W)) u_next (
    .op_i   (op_i),
    .cur_i  (cnt_q),
    .bus_i  (bus_i),
    .uaddr_i(uaddr_i),
    .nxt_o  (cnt_d),
    .act_o  (act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (act) begin
      cnt_q  <= cnt_d;
      flag_q <= (cnt_d == '0);
    end
  end

  assign count_o     = cnt_q;
  assign zero_flag_o = flag_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b00 |=> $stable(count_o) && $stable(zero_flag_o));
  p_dec_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b01 |=> count_o == CNT_W'($past(count_o) - 1'b1));
  p_bus_ld_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b10 |=> count_o == CNT_W'($past(bus_i)));
  p_ua_msb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 2'b11 |=> count_o[CNT_W-1] == 1'b0);
  p_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i != 2'b00 |=> zero_flag_o == (count_o == '0));
  p_rst_r1: assert property (@(posedge clk_i)
    !rst_ni |-> count_o == '0 && !zero_flag_o);
endmodule

// File: tb/sim_loop_counter.sv
module sim_loop_counter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  op = 0;
  logic [15:0] bus = 0;
  logic [6:0]  ua = 0;
  logic [7:0]  cnt;
  logic        flg;
  int n_chk = 0, n_err = 0;
  logic [7:0] m_cnt = 0;
  logic       m_flg = 0;

  always #5 clk = ~clk;

  loop_counter u0 (.clk_i(clk), .rst_ni(rst_n), .op_i(op), .bus_i(bus),
                   .uaddr_i(ua), .count_o(cnt), .zero_flag_o(flg));

  function automatic logic [7:0] model_next(logic [1:0] o, logic [7:0] c,
                                            logic [15:0] b, logic [6:0] u);
    case (o)
      2'b01:   return c - 8'd1;
      2'b10:   return b[7:0];
      2'b11:   return {1'b0, u};
      default: return c;
    endcase
  endfunction

  task automatic check(string req);
    n_chk++;
    if (cnt !== m_cnt || flg !== m_flg) begin
      n_err++;
      $display("FAIL %s: got cnt=%02h flag=%0b, expected cnt=%02h flag=%0b",
               req, cnt, flg, m_cnt, m_flg);
    end
  endtask

  task automatic step(logic [1:0] o, logic [15:0] b, logic [6:0] u, string req);
    op = o; bus = b; ua = u;
    @(posedge clk);
    if (o != 2'b00) begin
      m_cnt = model_next(o, m_cnt, b, u);
      m_flg = (m_cnt == 8'd0);
    end
    #2 check(req);
  endtask

  initial begin
    #200000000;
    n_err++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    op = 2'b10; bus = 16'h0000;
    repeat (2) @(posedge clk);
    #2 check("R1");
    @(negedge clk); rst_n = 1;
    step(2'b10, 16'h000A, 0, "R4");
    step(2'b10, 16'h0000, 0, "R6");
    step(2'b10, 16'h0000, 0, "R7");
    step(2'b00, 16'h0055, 7'h12, "R2");
    step(2'b10, 16'h0002, 0, "R7");
    step(2'b10, 16'hFF1A, 0, "R4");
    step(2'b11, 16'h0000, 7'h7F, "R5");
    step(2'b11, 16'h0000, 7'h00, "R5");
    step(2'b11, 16'h0000, 7'h0A, "R5");
    step(2'b10, 16'h0001, 0, "R4");
    step(2'b01, 0, 0, "R6");
    step(2'b00, 0, 0, "R2");
    step(2'b01, 0, 0, "R3");
    step(2'b01, 0, 0, "R3");
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] o;
      logic [15:0] b;
      int r;
      r = $urandom % 10;
      o = (r < 4) ? 2'b01 : (r < 6) ? 2'b00 : (r < 8) ? 2'b10 : 2'b11;
      b = ($urandom % 3 == 0) ? {8'($urandom), 8'h00} : 16'($urandom % 4 == 0 ? $urandom : $urandom % 3);
      step(o, b, 7'($urandom % 4 == 0 ? 0 : $urandom), "R6");
    end
    @(negedge clk); rst_n = 0; op = 2'b11; ua = 7'h05;
    m_cnt = 0; m_flg = 0;
    #1 check("R1");
    @(posedge clk); #2 check("R1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin : seed
    int s;
    s = $urandom(32'd1234);
  end
endmodule